// File: doc/BRIEF.md
# Management-Mapped Controller Program Loader

This block is the register slave that lets a host load and start the embedded controller of a 10G PHY. It sits on a parallel management bus that carries a device number, a 16-bit register address, 16-bit write data, a one-cycle write strobe, a one-cycle read strobe and returned read data. Through that bus the host reads a fixed revision word, holds or releases the controller with a reset register, picks whether the controller boots from its internal ROM or from program SRAM, and fills the byte-wide program SRAM.

The program SRAM is split into two management windows that both start at register address 8000h. The lower part of the program lives in device 3, the upper part in device 4, and each management write stores one byte, taken from the low half of the write data. The usual load sequence is: hold the controller in reset, point it at ROM, fill both windows, then release reset and switch the boot source to SRAM. Once the controller runs from SRAM the windows are locked against writes. A separate read port lets the controller fetch program bytes.

The window sizes are parameters (`LO_BYTES`, `HI_BYTES`). A full product instance uses 16384 and 8192, giving 24 KB; the defaults are smaller so that the default elaboration stays light.

Top module: `mdl_loader`

## Requirements
- R1: A read of device 1, address D001h returns the revision word, whose upper byte is B3h and whose lower byte is the `REV_LO` parameter; writes to that address change nothing.
- R2: Device 1, address C300h is the controller reset register. After reset it reads 0000h and `mcu_rst_n` is 0. A write with bit 1 set releases the controller (`mcu_rst_n` = 1, reads 0002h), a write with bit 1 clear holds it (`mcu_rst_n` = 0, reads 0000h); all other bits of the write are discarded and read as 0.
- R3: Device 3, address E854h is the boot source register. After reset it reads 00C0h and `boot_sram` is 0. Writing exactly 0040h selects SRAM (`boot_sram` = 1, reads 0040h), writing exactly 00C0h selects ROM (`boot_sram` = 0, reads 00C0h); any other value leaves it unchanged.
- R4: A write to device 3, address 8000h+i with i < `LO_BYTES` stores wdata[7:0] as program byte i.
- R5: A write to device 4, address 8000h+j with j < `HI_BYTES` stores wdata[7:0] as program byte `LO_BYTES`+j.
- R6: Program writes are dropped while the controller is both out of reset and booting from SRAM (`mcu_rst_n` = 1 and `boot_sram` = 1); they are accepted in every other state.
- R7: A read strobe at a window address returns the stored byte zero-extended to 16 bits on `mgmt_rdata` in the cycle after the strobe; without a read strobe `mgmt_rdata` keeps its value.
- R8: Reads of any address that is neither a register above nor inside a window return 0000h, and writes there (including window addresses past a window's end and window addresses in other devices) store nothing.
- R9: `code_data` shows program byte `code_addr` one cycle after `code_addr` is presented, and 00h when `code_addr` is `LO_BYTES`+`HI_BYTES` or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_mmd | input | 5 | Device number of the access |
| mgmt_addr | input | 16 | Register address of the access |
| mgmt_wdata | input | 16 | Write data |
| mgmt_wr | input | 1 | Write strobe, one cycle per access |
| mgmt_rd | input | 1 | Read strobe, one cycle per access |
| mgmt_rdata | output | 16 | Read data, valid the cycle after the read strobe |
| mcu_rst_n | output | 1 | Controller run line, 0 holds the controller in reset |
| boot_sram | output | 1 | 1 when the controller boots from program SRAM |
| code_addr | input | CA_W | Controller fetch address |
| code_data | output | 8 | Program byte at the fetch address, one cycle later |

## Verification
The assertions assume that a read and a write strobe never arrive in the same cycle and that every strobe lasts one cycle with device, address and data steady alongside it; the stimulus drives each access as a single strobed cycle from the falling edge and never overlaps the two kinds. They also assume the program bytes have been written before they are read, so the bench first fills every byte through both windows before any random reads. Random traffic then mixes window accesses near and past both window ends, register writes with the two magic boot values and arbitrary values, and accesses in unrelated devices, so the lock condition is entered and left many times.

// File: rtl/mdl_pkg.sv
package mdl_pkg;

    localparam logic [4:0]  DEV_PMA   = 5'd1;
    localparam logic [4:0]  DEV_PCS   = 5'd3;
    localparam logic [4:0]  DEV_XS    = 5'd4;

    localparam logic [15:0] ADR_REV   = 16'hD001;
    localparam logic [15:0] ADR_RUN   = 16'hC300;
    localparam logic [15:0] ADR_BOOT  = 16'hE854;
    localparam logic [15:0] ADR_WIN   = 16'h8000;

    localparam logic [15:0] BOOT_ROM  = 16'h00C0;
    localparam logic [15:0] BOOT_RAM  = 16'h0040;

    localparam logic [7:0]  REV_HI    = 8'hB3;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_REV,
        TGT_RUN,
        TGT_BOOT,
        TGT_LO,
        TGT_HI
    } tgt_e;

endpackage

// File: rtl/mdl_decode.sv
module mdl_decode
    import mdl_pkg::*;
#(
    parameter int unsigned LO_BYTES = 1024,
    parameter int unsigned HI_BYTES = 512,
    parameter int unsigned IDX_W    = 11
) (
    input  logic [4:0]       mmd,
    input  logic [15:0]      addr,
    output tgt_e             tgt,
    output logic [IDX_W-1:0] idx
);

    logic [15:0] off;
    logic        above;
    logic        fits_lo;
    logic        fits_hi;

    always_comb begin
        off     = addr - ADR_WIN;
        above   = (addr >= ADR_WIN);
        fits_lo = above && ({16'd0, off} < 32'(LO_BYTES));
        fits_hi = above && ({16'd0, off} < 32'(HI_BYTES));
        tgt     = TGT_NONE;
        idx     = '0;
        if (mmd == DEV_PMA && addr == ADR_REV) begin
            tgt = TGT_REV;
        end else if (mmd == DEV_PMA && addr == ADR_RUN) begin
            tgt = TGT_RUN;
        end else if (mmd == DEV_PCS && addr == ADR_BOOT) begin
            tgt = TGT_BOOT;
        end else if (mmd == DEV_PCS && fits_lo) begin
            tgt = TGT_LO;
            idx = IDX_W'({16'd0, off});
        end else if (mmd == DEV_XS && fits_hi) begin
            tgt = TGT_HI;
            idx = IDX_W'({16'd0, off} + 32'(LO_BYTES));
        end
    end

endmodule

// File: rtl/mdl_ctrl.sv
module mdl_ctrl
    import mdl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  tgt_e        tgt,
    input  logic [15:0] wdata,
    output logic        run,
    output logic        sram
);

    typedef struct packed {
        logic run;
        logic sram;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr && tgt == TGT_RUN) begin
            st_d.run = wdata[1];
        end
        if (wr && tgt == TGT_BOOT) begin
            if (wdata == BOOT_RAM) begin
                st_d.sram = 1'b1;
            end else if (wdata == BOOT_ROM) begin
                st_d.sram = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run  = st_q.run;
    assign sram = st_q.sram;

    // R2: a write with the run bit clear keeps the controller held
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && tgt == TGT_RUN && !wdata[1]) |=> !run);

    // R2: a write with the run bit set releases the controller
    p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && tgt == TGT_RUN && wdata[1]) |=> run);

    // R3: a non-magic value leaves the boot source untouched
    p_boot_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && tgt == TGT_BOOT && wdata != BOOT_ROM && wdata != BOOT_RAM)
        |=> $stable(sram));

    // R3: boot source moves only on a boot register write
    p_boot_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && tgt == TGT_BOOT) |=> $stable(sram));

endmodule

// File: rtl/mdl_progmem.sv
module mdl_progmem #(
    parameter int unsigned DEPTH = 1536,
    parameter int unsigned IDX_W = 11,
    parameter int unsigned CA_W  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wbyte,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rbyte,
    input  logic [CA_W-1:0]  code_addr,
    output logic [7:0]       code_data
);

    logic [7:0] mem [DEPTH];

    typedef struct packed {
        logic [7:0] code;
    } fetch_t;

    fetch_t fs_d, fs_q;

    always_ff @(posedge clk) begin
        if (we && (32'(widx) < 32'(DEPTH))) begin
            mem[widx] <= wbyte;
        end
    end

    always_comb begin
        rbyte = 8'h00;
        if (32'(ridx) < 32'(DEPTH)) begin
            rbyte = mem[ridx];
        end
    end

    always_comb begin
        fs_d.code = 8'h00;
        if (32'(code_addr) < 32'(DEPTH)) begin
            fs_d.code = mem[IDX_W'(code_addr)];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q <= '0;
        end else begin
            fs_q <= fs_d;
        end
    end

    assign code_data = fs_q.code;

    // R9: fetches past the end of program memory return zero
    p_code_oob_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(code_addr) >= 32'(DEPTH)) |=> (code_data == 8'h00));

    // R9: fetch data tracks a just-written byte at a steady address
    p_code_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && $stable(code_addr) && (32'(code_addr) == 32'(widx)))
        |=> ##1 ($stable(code_addr) -> (code_data == $past(wbyte, 2))));

endmodule

// File: rtl/mdl_loader.sv
module mdl_loader
    import mdl_pkg::*;
#(
    parameter int unsigned LO_BYTES = 1024,
    parameter int unsigned HI_BYTES = 512,
    parameter logic [7:0]  REV_LO   = 8'h00,
    localparam int unsigned TOTAL   = LO_BYTES + HI_BYTES,
    localparam int unsigned CA_W    = $clog2(TOTAL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      mgmt_mmd,
    input  logic [15:0]     mgmt_addr,
    input  logic [15:0]     mgmt_wdata,
    input  logic            mgmt_wr,
    input  logic            mgmt_rd,
    output logic [15:0]     mgmt_rdata,
    output logic            mcu_rst_n,
    output logic            boot_sram,
    input  logic [CA_W-1:0] code_addr,
    output logic [7:0]      code_data
);

    localparam int unsigned IDX_W   = CA_W;
    localparam logic [15:0] REV_VAL = {REV_HI, REV_LO};

    tgt_e             tgt;
    logic [IDX_W-1:0] idx;
    logic             run;
    logic             sram;
    logic             locked;
    logic             mem_we;
    logic [7:0]       mem_rbyte;

    typedef struct packed {
        logic [15:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    mdl_decode #(
        .LO_BYTES (LO_BYTES),
        .HI_BYTES (HI_BYTES),
        .IDX_W    (IDX_W)
    ) i_decode (
        .mmd  (mgmt_mmd),
        .addr (mgmt_addr),
        .tgt  (tgt),
        .idx  (idx)
    );

    mdl_ctrl i_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (mgmt_wr),
        .tgt   (tgt),
        .wdata (mgmt_wdata),
        .run   (run),
        .sram  (sram)
    );

    assign locked = run && sram;
    assign mem_we = mgmt_wr && !locked && (tgt == TGT_LO || tgt == TGT_HI);

    mdl_progmem #(
        .DEPTH (TOTAL),
        .IDX_W (IDX_W),
        .CA_W  (CA_W)
    ) i_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (mem_we),
        .widx      (idx),
        .wbyte     (mgmt_wdata[7:0]),
        .ridx      (idx),
        .rbyte     (mem_rbyte),
        .code_addr (code_addr),
        .code_data (code_data)
    );

    always_comb begin
        rd_d = rd_q;
        if (mgmt_rd) begin
            unique case (tgt)
                TGT_REV:  rd_d.rdata = REV_VAL;
                TGT_RUN:  rd_d.rdata = {14'd0, run, 1'b0};
                TGT_BOOT: rd_d.rdata = sram ? BOOT_RAM : BOOT_ROM;
                TGT_LO,
                TGT_HI:   rd_d.rdata = {8'h00, mem_rbyte};
                default:  rd_d.rdata = 16'h0000;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign mgmt_rdata = rd_q.rdata;
    assign mcu_rst_n  = run;
    assign boot_sram  = sram;

    // R1: revision word comes back on the cycle after its read strobe
    p_rev_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_rd && mgmt_mmd == DEV_PMA && mgmt_addr == ADR_REV)
        |=> (mgmt_rdata[15:8] == REV_HI));

    // R6: the memory write enable never fires while running from SRAM
    p_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !(mcu_rst_n && boot_sram));

    // R7: read data holds when no read strobe is given
    p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mgmt_rd |=> $stable(mgmt_rdata));

    // R7: window reads carry a zero upper byte
    p_win_zext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_rd && (tgt == TGT_LO || tgt == TGT_HI))
        |=> (mgmt_rdata[15:8] == 8'h00));

    // R8: unmapped reads return zero
    p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_rd && tgt == TGT_NONE) |=> (mgmt_rdata == 16'h0000));

    // R8: no memory write on an address outside both windows
    p_no_stray_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_wr && !(mgmt_mmd == DEV_PCS || mgmt_mmd == DEV_XS)) |-> !mem_we);

endmodule

// File: tb/test_mdl_loader.sv
module test_mdl_loader;

    localparam int unsigned LO     = 1024;
    localparam int unsigned HI     = 512;
    localparam int unsigned TOT    = LO + HI;
    localparam int unsigned CAW    = $clog2(TOT);
    localparam logic [7:0]  REVLO  = 8'h3B;
    localparam time         PERIOD = 10ns;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4:0]      mgmt_mmd = '0;
    logic [15:0]     mgmt_addr = '0;
    logic [15:0]     mgmt_wdata = '0;
    logic            mgmt_wr = 1'b0;
    logic            mgmt_rd = 1'b0;
    logic [15:0]     mgmt_rdata;
    logic            mcu_rst_n;
    logic            boot_sram;
    logic [CAW-1:0]  code_addr = '0;
    logic [7:0]      code_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] mem_m [TOT];
    logic run_m  = 1'b0;
    logic sram_m = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    mdl_loader #(.LO_BYTES(LO), .HI_BYTES(HI), .REV_LO(REVLO)) i_mdl_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .mgmt_mmd   (mgmt_mmd),
        .mgmt_addr  (mgmt_addr),
        .mgmt_wdata (mgmt_wdata),
        .mgmt_wr    (mgmt_wr),
        .mgmt_rd    (mgmt_rd),
        .mgmt_rdata (mgmt_rdata),
        .mcu_rst_n  (mcu_rst_n),
        .boot_sram  (boot_sram),
        .code_addr  (code_addr),
        .code_data  (code_data)
    );

    function automatic int win_idx(logic [4:0] m, logic [15:0] a);
        int o;
        o = int'(a) - 32'h8000;
        if (m == 5'd3 && o >= 0 && o < int'(LO)) return o;
        if (m == 5'd4 && o >= 0 && o < int'(HI)) return int'(LO) + o;
        return -1;
    endfunction

    function automatic logic [15:0] exp_read(logic [4:0] m, logic [15:0] a);
        int w;
        if (m == 5'd1 && a == 16'hD001) return {8'hB3, REVLO};
        if (m == 5'd1 && a == 16'hC300) return {14'd0, run_m, 1'b0};
        if (m == 5'd3 && a == 16'hE854) return sram_m ? 16'h0040 : 16'h00C0;
        w = win_idx(m, a);
        if (w >= 0) return {8'h00, mem_m[w]};
        return 16'h0000;
    endfunction

    function automatic string req_of(logic [4:0] m, logic [15:0] a);
        if (m == 5'd1 && a == 16'hD001) return "R1";
        if (m == 5'd1 && a == 16'hC300) return "R2";
        if (m == 5'd3 && a == 16'hE854) return "R3";
        if (win_idx(m, a) >= 0) return "R7";
        return "R8";
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic mwrite(logic [4:0] m, logic [15:0] a, logic [15:0] d);
        int w;
        @(negedge clk);
        mgmt_mmd = m; mgmt_addr = a; mgmt_wdata = d; mgmt_wr = 1'b1;
        @(negedge clk);
        mgmt_wr = 1'b0;
        w = win_idx(m, a);
        if (w >= 0 && !(run_m && sram_m)) mem_m[w] = d[7:0];
        if (m == 5'd1 && a == 16'hC300) run_m = d[1];
        if (m == 5'd3 && a == 16'hE854) begin
            if (d == 16'h0040) sram_m = 1'b1;
            else if (d == 16'h00C0) sram_m = 1'b0;
        end
    endtask

    task automatic mread(logic [4:0] m, logic [15:0] a, output logic [15:0] v);
        @(negedge clk);
        mgmt_mmd = m; mgmt_addr = a; mgmt_rd = 1'b1;
        @(negedge clk);
        mgmt_rd = 1'b0;
        v = mgmt_rdata;
    endtask

    task automatic rcheck(string req, logic [4:0] m, logic [15:0] a);
        logic [15:0] v;
        mread(m, a, v);
        check(req, 32'(v), 32'(exp_read(m, a)));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state: R2, R3
        check("R2", 32'(mcu_rst_n), 32'd0);
        check("R3", 32'(boot_sram), 32'd0);
        check("R7", 32'(mgmt_rdata), 32'd0);
        rcheck("R2", 5'd1, 16'hC300);
        rcheck("R3", 5'd3, 16'hE854);
        rcheck("R1", 5'd1, 16'hD001);
        // R1: write to revision ignored
        mwrite(5'd1, 16'hD001, 16'h1234);
        rcheck("R1", 5'd1, 16'hD001);

        // fill both windows: R4, R5
        for (int i = 0; i < int'(LO); i++)
            mwrite(5'd3, 16'(32'h8000 + i), 16'($urandom));
        for (int j = 0; j < int'(HI); j++)
            mwrite(5'd4, 16'(32'h8000 + j), 16'($urandom));
        rcheck("R4", 5'd3, 16'h8000);
        rcheck("R4", 5'd3, 16'(32'h8000 + LO - 1));
        rcheck("R5", 5'd4, 16'h8000);
        rcheck("R5", 5'd4, 16'(32'h8000 + HI - 1));

        // R8: past window ends and wrong devices store nothing
        mwrite(5'd3, 16'(32'h8000 + LO), 16'h00AA);
        mwrite(5'd4, 16'(32'h8000 + HI), 16'h00BB);
        mwrite(5'd1, 16'h8000, 16'h00CC);
        mwrite(5'd7, 16'h8000, 16'h00DD);
        rcheck("R8", 5'd3, 16'(32'h8000 + LO));
        rcheck("R8", 5'd4, 16'(32'h8000 + HI));
        rcheck("R8", 5'd1, 16'h8000);
        rcheck("R4", 5'd3, 16'h8000);
        rcheck("R5", 5'd4, 16'h8000);
        rcheck("R4", 5'd3, 16'(32'h8000 + LO - 1));
        rcheck("R5", 5'd4, 16'(32'h8000 + HI - 1));

        // R2: other bits discarded
        mwrite(5'd1, 16'hC300, 16'hFFFE);
        check("R2", 32'(mcu_rst_n), 32'd1);
        rcheck("R2", 5'd1, 16'hC300);
        // R3: non-magic ignored, magic values switch
        mwrite(5'd3, 16'hE854, 16'h0041);
        check("R3", 32'(boot_sram), 32'd0);
        mwrite(5'd3, 16'hE854, 16'h0040);
        check("R3", 32'(boot_sram), 32'd1);
        rcheck("R3", 5'd3, 16'hE854);

        // R6: locked now, write dropped
        mwrite(5'd3, 16'h8005, {8'h00, ~mem_m[5]});
        rcheck("R6", 5'd3, 16'h8005);
        mwrite(5'd4, 16'h8007, {8'h00, ~mem_m[LO + 7]});
        rcheck("R6", 5'd4, 16'h8007);
        // R6: held in reset while booting SRAM accepts writes
        mwrite(5'd1, 16'hC300, 16'h0000);
        check("R2", 32'(mcu_rst_n), 32'd0);
        mwrite(5'd3, 16'h8005, 16'h005A);
        rcheck("R6", 5'd3, 16'h8005);
        mwrite(5'd3, 16'hE854, 16'h00C0);
        check("R3", 32'(boot_sram), 32'd0);

        // R7: rdata holds without strobe
        mread(5'd1, 16'hD001, v);
        repeat (3) @(negedge clk);
        check("R7", 32'(mgmt_rdata), 32'({8'hB3, REVLO}));

        // random traffic
        for (int n = 0; n < 1500; n++) begin
            int k;
            logic [4:0]  m;
            logic [15:0] a;
            logic [15:0] d;
            k = int'($urandom_range(0, 9));
            d = 16'($urandom);
            case (k)
                0, 1, 2, 3: begin m = 5'd3; a = 16'(32'h8000 + $urandom_range(0, LO + 3)); end
                4, 5, 6:    begin m = 5'd4; a = 16'(32'h8000 + $urandom_range(0, HI + 3)); end
                7: begin
                    case ($urandom_range(0, 2))
                        0: begin m = 5'd1; a = 16'hD001; end
                        1: begin m = 5'd1; a = 16'hC300; end
                        default: begin m = 5'd3; a = 16'hE854; end
                    endcase
                    case ($urandom_range(0, 4))
                        0: d = 16'h0000;
                        1: d = 16'h0002;
                        2: d = 16'h0040;
                        3: d = 16'h00C0;
                        default: ;
                    endcase
                end
                8: begin m = 5'($urandom); a = 16'($urandom); end
                default: begin m = ($urandom_range(0, 1) != 0) ? 5'd1 : 5'd7; a = 16'(32'h8000 + $urandom_range(0, 15)); end
            endcase
            if ($urandom_range(0, 9) < 6) begin
                mwrite(m, a, d);
                check("R2", 32'(mcu_rst_n), 32'(run_m));
                check("R3", 32'(boot_sram), 32'(sram_m));
            end else begin
                rcheck(req_of(m, a), m, a);
            end
        end

        // R9: controller fetch port
        for (int n = 0; n < 300; n++) begin
            int ca;
            ca = int'($urandom_range(0, (1 << CAW) - 1));
            if (n == 0) ca = 0;
            if (n == 1) ca = int'(TOT) - 1;
            if (n == 2) ca = int'(TOT);
            @(negedge clk);
            code_addr = CAW'(ca);
            @(negedge clk);
            check("R9", 32'(code_data), (ca < int'(TOT)) ? 32'(mem_m[ca]) : 32'd0);
        end

        finish_run();
    end

endmodule